// File: doc/BRIEF.md
# Debug Watchpoint Sequencer

This block observes the execution events a CPU core reports each cycle: a fetch address, an operand address with a write flag, the fetched instruction word, a taken branch with its target, the running process identifier and the current instruction-set mode. It also observes an external active-low trigger input. Four channels compare these events against programmed values and raise a one-cycle hit pulse when their condition is met. Each channel can also pulse an active-low trigger-out pin.

A channel can be qualified by process identifier and by mode. It can count a programmed number of matching events before it fires. It can also be chained behind another channel, so that it is armed only once that predecessor has fired. Chaining lets software build an ordered sequence of conditions. When the last stage fires the sequence falls back to waiting on its first stage.

Configuration goes through a write-only register port. The address is `{channel, select}`. Select 0 is the control word, 1 is the low bound or compare value, 2 is the high bound or mask, and 3 is a clear strobe.

Top module: `wp_seq_top`

## Requirements
- R1: After reset every channel is disabled, `hit_o` is all zero and `trig_out_n` is high.
- R2: Kind 0 (fetch) counts an event when `fetch_valid` is high and `lo <= fetch_addr <= hi`. Both bounds are inclusive, so `lo == hi` gives a single-address breakpoint.
- R3: Kind 1 (operand write) counts an event only when `op_valid` and `op_write` are both high and `lo <= op_addr <= hi`. Reads never match.
- R4: Kind 2 (instruction value) counts an event when `fetch_valid` is high and `((insn_word ^ lo) & hi) == 0`, where the high register acts as a per-bit compare mask.
- R5: Kind 3 (branch) counts an event when `br_taken` is high and `lo <= br_target <= hi`.
- R6: Kind 4 (external) counts an event in every cycle in which `trig_in_n` is low. Kinds 5 to 7 never match.
- R7: A channel with reload value N fires on every (N+1)-th counted event. Its event count then restarts from zero.
- R8: A channel with the chain bit set counts events only while armed. It becomes armed at the edge where its predecessor fires, and it is disarmed by its own hit. An unchained channel is always armed.
- R9: With the process don't-care bit clear, events count only when `cur_pid` equals the channel's process field.
- R10: With the mode don't-care bit clear, events count only when `cur_mode` equals the channel's mode bit.
- R11: `hit_o[c]` is high for the single cycle after the clock edge on which channel c's final counted event is sampled. In that same cycle `trig_out_n` is low if any hitting channel has its trigger-out enable set; otherwise `trig_out_n` stays high.
- R12: Control word layout is as follows. Bit 0 is enable. Bits 3:1 are the kind. Bit 4 is chain. Bits 6:5 are the predecessor index. Bit 7 is trigger-out enable. Bits 15:8 are the process identifier and bit 16 is its don't-care. Bit 17 is the mode and bit 18 is its don't-care. Bits 31:24 are the reload value. `cfg_addr[3:2]` selects the channel and `cfg_addr[1:0]` selects the register. A write to the control word or to the clear strobe (select 3) zeroes that channel's count and disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Channel (bits 3:2) and register select (bits 1:0) |
| cfg_wdata | input | 32 | Configuration write data |
| fetch_valid | input | 1 | Fetch address and instruction word are valid |
| fetch_addr | input | 32 | Instruction fetch address |
| insn_word | input | 32 | Fetched instruction word |
| op_valid | input | 1 | Operand access valid |
| op_write | input | 1 | Operand access is a write |
| op_addr | input | 32 | Operand address |
| br_taken | input | 1 | A branch was taken this cycle |
| br_target | input | 32 | Taken branch target |
| cur_pid | input | 8 | Current process identifier |
| cur_mode | input | 1 | Current instruction-set mode |
| trig_in_n | input | 1 | External trigger input, active low |
| hit_o | output | 4 | Per-channel hit pulse |
| trig_out_n | output | 1 | External trigger output, active low |

## Verification
The assertions assume that `cur_pid`, `cur_mode` and the configuration port always carry defined values. They judge the mode and process qualifiers against values sampled one edge before the hit. The bench meets this by driving every input at the falling edge and holding all event inputs idle while a configuration word is written, so a qualifier never changes under a live comparison. Directed phases cover each match kind, its bounds, counting, chaining and clearing. A final phase programs all four channels at once with small ranges, so that chains, counters and qualifiers interact under pseudo-random events.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int NCH    = 4;
    localparam int AW     = 32;
    localparam int IW     = 32;
    localparam int DW     = 32;
    localparam int PID_W  = 8;
    localparam int CNT_W  = 8;
    localparam int PRED_W = $clog2(NCH);
    localparam int SEL_W  = 2;
    localparam int CFG_AW = PRED_W + SEL_W;

    // control word bit positions
    localparam int CTL_EN     = 0;
    localparam int CTL_KIND   = 1;
    localparam int CTL_CHAIN  = 4;
    localparam int CTL_PRED   = 5;
    localparam int CTL_TOUT   = 7;
    localparam int CTL_PID    = 8;
    localparam int CTL_PIDDC  = CTL_PID + PID_W;
    localparam int CTL_MODE   = CTL_PIDDC + 1;
    localparam int CTL_MODEDC = CTL_MODE + 1;
    localparam int CTL_REL    = DW - CNT_W;

    typedef enum logic [2:0] {
        WK_FETCH  = 3'd0,
        WK_OPWR   = 3'd1,
        WK_INSN   = 3'd2,
        WK_BRANCH = 3'd3,
        WK_TRIGIN = 3'd4
    } wp_kind_e;

    typedef struct packed {
        logic              en;
        wp_kind_e          kind;
        logic              chain;
        logic [PRED_W-1:0] pred;
        logic              tout;
        logic [PID_W-1:0]  pid;
        logic              pid_dc;
        logic              mode;
        logic              mode_dc;
        logic [CNT_W-1:0]  reload;
        logic [AW-1:0]     lo;
        logic [AW-1:0]     hi;
    } wp_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } wp_chan_st_t;

endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
    import wp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [DW-1:0]              cfg_wdata,
    output wp_cfg_t [NCH-1:0]          cfg_o,
    output logic [NCH-1:0]             clr_o
);

    typedef struct packed {
        wp_cfg_t [NCH-1:0] cfg;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [PRED_W-1:0] ch;
    logic              unused_wbits;

    assign unused_wbits = ^cfg_wdata[CTL_REL-1:CTL_MODEDC+1];

    always_comb begin
        regs_d = regs_q;
        clr_o  = '0;
        ch     = cfg_addr[CFG_AW-1:SEL_W];
        if (cfg_we) begin
            case (cfg_addr[SEL_W-1:0])
                2'd0: begin
                    regs_d.cfg[ch].en      = cfg_wdata[CTL_EN];
                    regs_d.cfg[ch].kind    = wp_kind_e'(cfg_wdata[CTL_KIND +: 3]);
                    regs_d.cfg[ch].chain   = cfg_wdata[CTL_CHAIN];
                    regs_d.cfg[ch].pred    = cfg_wdata[CTL_PRED +: PRED_W];
                    regs_d.cfg[ch].tout    = cfg_wdata[CTL_TOUT];
                    regs_d.cfg[ch].pid     = cfg_wdata[CTL_PID +: PID_W];
                    regs_d.cfg[ch].pid_dc  = cfg_wdata[CTL_PIDDC];
                    regs_d.cfg[ch].mode    = cfg_wdata[CTL_MODE];
                    regs_d.cfg[ch].mode_dc = cfg_wdata[CTL_MODEDC];
                    regs_d.cfg[ch].reload  = cfg_wdata[CTL_REL +: CNT_W];
                    clr_o[ch]              = 1'b1;
                end
                2'd1:    regs_d.cfg[ch].lo = cfg_wdata[AW-1:0];
                2'd2:    regs_d.cfg[ch].hi = cfg_wdata[AW-1:0];
                default: clr_o[ch] = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg_o = regs_q.cfg;

endmodule

// File: rtl/wp_channel.sv
module wp_channel
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wp_cfg_t          cfg,
    input  logic             clr,
    input  logic             pred_fire,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_addr,
    input  logic [IW-1:0]    insn_word,
    input  logic             op_valid,
    input  logic             op_write,
    input  logic [AW-1:0]    op_addr,
    input  logic             br_taken,
    input  logic [AW-1:0]    br_target,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             cur_mode,
    input  logic             trig_in_n,
    output logic             hit,
    output logic             armed
);

    wp_chan_st_t st_d, st_q;
    logic        raw, pid_ok, mode_ok, event_ok;
    logic        unused_fields;

    assign unused_fields = ^{cfg.tout, cfg.pred};

    always_comb begin
        case (cfg.kind)
            WK_FETCH:  raw = fetch_valid && (fetch_addr >= cfg.lo) && (fetch_addr <= cfg.hi);
            WK_OPWR:   raw = op_valid && op_write && (op_addr >= cfg.lo) && (op_addr <= cfg.hi);
            WK_INSN:   raw = fetch_valid && (((insn_word ^ cfg.lo[IW-1:0]) & cfg.hi[IW-1:0]) == '0);
            WK_BRANCH: raw = br_taken && (br_target >= cfg.lo) && (br_target <= cfg.hi);
            WK_TRIGIN: raw = !trig_in_n;
            default:   raw = 1'b0;
        endcase
        pid_ok   = cfg.pid_dc || (cur_pid == cfg.pid);
        mode_ok  = cfg.mode_dc || (cur_mode == cfg.mode);
        event_ok = cfg.en && (!cfg.chain || st_q.armed) && pid_ok && mode_ok && raw;
        hit      = event_ok && (st_q.cnt == cfg.reload);

        st_d = st_q;
        if (event_ok) st_d.cnt = hit ? '0 : st_q.cnt + 1'b1;
        if (hit)       st_d.armed = 1'b0;
        if (pred_fire) st_d.armed = 1'b1;
        if (clr)       st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/wp_seq_top.sv
module wp_seq_top
    import wp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic                 fetch_valid,
    input  logic [AW-1:0]        fetch_addr,
    input  logic [IW-1:0]        insn_word,
    input  logic                 op_valid,
    input  logic                 op_write,
    input  logic [AW-1:0]        op_addr,
    input  logic                 br_taken,
    input  logic [AW-1:0]        br_target,
    input  logic [PID_W-1:0]     cur_pid,
    input  logic                 cur_mode,
    input  logic                 trig_in_n,
    output logic [NCH-1:0]       hit_o,
    output logic                 trig_out_n
);

    typedef struct packed {
        logic [NCH-1:0] hit;
        logic           trig_n;
    } out_t;

    wp_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]    clr;
    logic [NCH-1:0]    hit_raw;
    logic [NCH-1:0]    pred_fire;
    logic [NCH-1:0]    armed;
    out_t              out_d, out_q;

    wp_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg),
        .clr_o     (clr)
    );

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            pred_fire[c] = hit_raw[cfg[c].pred];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wp_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg         (cfg[c]),
            .clr         (clr[c]),
            .pred_fire   (pred_fire[c]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .insn_word   (insn_word),
            .op_valid    (op_valid),
            .op_write    (op_write),
            .op_addr     (op_addr),
            .br_taken    (br_taken),
            .br_target   (br_target),
            .cur_pid     (cur_pid),
            .cur_mode    (cur_mode),
            .trig_in_n   (trig_in_n),
            .hit         (hit_raw[c]),
            .armed       (armed[c])
        );
    end

    always_comb begin
        out_d.hit    = hit_raw;
        out_d.trig_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            if (hit_raw[c] && cfg[c].tout) out_d.trig_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{hit: '0, trig_n: 1'b1};
        else        out_q <= out_d;
    end

    assign hit_o      = out_q.hit;
    assign trig_out_n = out_q.trig_n;

endmodule

// File: rtl/wp_seq_chk.sv
module wp_seq_chk
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wp_cfg_t [NCH-1:0] cfg,
    input  logic [NCH-1:0]    armed,
    input  logic [NCH-1:0]    hit_o,
    input  logic              trig_out_n,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic              cur_mode
);

    logic [NCH-1:0] tout_vec;
    logic           unused_cfg;

    always_comb begin
        for (int c = 0; c < NCH; c++) tout_vec[c] = cfg[c].tout;
    end
    assign unused_cfg = ^cfg;

    // R11
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out_n == !(|(hit_o & $past(tout_vec))));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1
        en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o[c] |-> $past(cfg[c].en));

        // R8
        chain_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o[c] && $past(cfg[c].chain)) |-> $past(armed[c]));

        // R10
        mode_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o[c] && !$past(cfg[c].mode_dc)) |-> ($past(cur_mode) == $past(cfg[c].mode)));

        // R9
        pid_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o[c] && !$past(cfg[c].pid_dc)) |-> ($past(cur_pid) == $past(cfg[c].pid)));
    end

endmodule

bind wp_seq_top wp_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .armed      (armed),
    .hit_o      (hit_o),
    .trig_out_n (trig_out_n),
    .cur_pid    (cur_pid),
    .cur_mode   (cur_mode)
);

// File: tb/test_wp_seq_top.sv
`timescale 1ns/1ps
module test_wp_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] insn_word = '0;
    logic        op_valid = 1'b0;
    logic        op_write = 1'b0;
    logic [31:0] op_addr = '0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic [7:0]  cur_pid = '0;
    logic        cur_mode = 1'b0;
    logic        trig_in_n = 1'b1;
    logic [3:0]  hit_o;
    logic        trig_out_n;

    always #2.5 clk = ~clk;

    wp_seq_top i_wp_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .insn_word(insn_word),
        .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr),
        .br_taken(br_taken), .br_target(br_target), .cur_pid(cur_pid), .cur_mode(cur_mode),
        .trig_in_n(trig_in_n), .hit_o(hit_o), .trig_out_n(trig_out_n)
    );

    // behavioural reference state
    bit          m_en[4], m_chain[4], m_tout[4], m_piddc[4], m_mode[4], m_modedc[4], m_armed[4];
    int          m_kind[4], m_pred[4], m_pid[4], m_rel[4], m_cnt[4];
    logic [31:0] m_lo[4], m_hi[4];
    logic [3:0]  exp_hit = '0;
    logic        exp_tn = 1'b1;
    string       cur_req = "R1";
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    function automatic bit in_rng(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    task automatic model_update();
        bit ev[4];
        bit h[4];
        for (int c = 0; c < 4; c++) begin
            bit raw;
            case (m_kind[c])
                0: raw = fetch_valid && in_rng(fetch_addr, m_lo[c], m_hi[c]);
                1: raw = op_valid && op_write && in_rng(op_addr, m_lo[c], m_hi[c]);
                2: raw = fetch_valid && (((insn_word ^ m_lo[c]) & m_hi[c]) == 32'd0);
                3: raw = br_taken && in_rng(br_target, m_lo[c], m_hi[c]);
                4: raw = !trig_in_n;
                default: raw = 1'b0;
            endcase
            ev[c] = m_en[c] && (!m_chain[c] || m_armed[c]) && raw
                    && (m_piddc[c] || cur_pid == m_pid[c][7:0])
                    && (m_modedc[c] || cur_mode == m_mode[c]);
            h[c] = ev[c] && (m_cnt[c] == m_rel[c]);
        end
        exp_tn = 1'b1;
        for (int c = 0; c < 4; c++) begin
            exp_hit[c] = h[c];
            if (h[c] && m_tout[c]) exp_tn = 1'b0;
        end
        for (int c = 0; c < 4; c++) begin
            if (ev[c]) m_cnt[c] = h[c] ? 0 : m_cnt[c] + 1;
            if (h[c]) m_armed[c] = 1'b0;
            if (h[m_pred[c]]) m_armed[c] = 1'b1;
        end
        if (cfg_we) begin
            int ch;
            ch = cfg_addr[3:2];
            case (cfg_addr[1:0])
                2'd0: begin
                    m_en[ch]     = cfg_wdata[0];
                    m_kind[ch]   = cfg_wdata[3:1];
                    m_chain[ch]  = cfg_wdata[4];
                    m_pred[ch]   = cfg_wdata[6:5];
                    m_tout[ch]   = cfg_wdata[7];
                    m_pid[ch]    = cfg_wdata[15:8];
                    m_piddc[ch]  = cfg_wdata[16];
                    m_mode[ch]   = cfg_wdata[17];
                    m_modedc[ch] = cfg_wdata[18];
                    m_rel[ch]    = cfg_wdata[31:24];
                    m_cnt[ch] = 0; m_armed[ch] = 1'b0;
                end
                2'd1: m_lo[ch] = cfg_wdata;
                2'd2: m_hi[ch] = cfg_wdata;
                default: begin m_cnt[ch] = 0; m_armed[ch] = 1'b0; end
            endcase
        end
    endtask

    task automatic compare();
        checks++;
        if (hit_o !== exp_hit) begin
            errors++;
            $display("FAIL %s hit_o actual %b expected %b at %0t", cur_req, hit_o, exp_hit, $time);
        end
        checks++;
        if (trig_out_n !== exp_tn) begin
            errors++;
            $display("FAIL %s trig_out_n actual %b expected %b at %0t", cur_req, trig_out_n, exp_tn, $time);
        end
    endtask

    task automatic step();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        cfg_we = 1'b0; fetch_valid = 1'b0; op_valid = 1'b0; op_write = 1'b0;
        br_taken = 1'b0; trig_in_n = 1'b1;
    endtask

    task automatic wr(int ch, int sel, logic [31:0] d);
        idle_in();
        cfg_we = 1'b1; cfg_addr = {ch[1:0], sel[1:0]}; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic ctl(int ch, bit en, int kind, bit chain, int pred, bit tout,
                       int pid, bit piddc, bit mode, bit modedc, int rel);
        wr(ch, 0, {rel[7:0], 5'b0, modedc, mode, piddc, pid[7:0], tout, pred[1:0], chain, kind[2:0], en});
    endtask

    task automatic prog(int ch, int kind, int rel, logic [31:0] lo, logic [31:0] hi, bit tout);
        wr(ch, 1, lo);
        wr(ch, 2, hi);
        ctl(ch, 1'b1, kind, 1'b0, 0, tout, 0, 1'b1, 1'b0, 1'b1, rel);
    endtask

    task automatic all_off();
        for (int c = 0; c < 4; c++) ctl(c, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0);
    endtask

    task automatic fetch(logic [31:0] a);
        idle_in(); fetch_valid = 1'b1; fetch_addr = a; step();
    endtask

    task automatic operand(logic [31:0] a, bit w);
        idle_in(); op_valid = 1'b1; op_write = w; op_addr = a; step();
    endtask

    task automatic insn(logic [31:0] v);
        idle_in(); fetch_valid = 1'b1; fetch_addr = 32'hFFFF_0000; insn_word = v; step();
    endtask

    task automatic branch(logic [31:0] t, bit tk);
        idle_in(); br_taken = tk; br_target = t; step();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_en[c] = 0; m_chain[c] = 0; m_tout[c] = 0; m_piddc[c] = 0; m_mode[c] = 0;
            m_modedc[c] = 0; m_armed[c] = 0; m_kind[c] = 0; m_pred[c] = 0; m_pid[c] = 0;
            m_rel[c] = 0; m_cnt[c] = 0; m_lo[c] = '0; m_hi[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        compare();
        rst_n = 1'b1;
        step();
        fetch(32'h0);

        // R2: inclusive fetch range
        cur_req = "R2";
        prog(0, 0, 0, 32'h100, 32'h10F, 1'b1);
        fetch(32'hFF); fetch(32'h100); fetch(32'h108); fetch(32'h10F); fetch(32'h110);
        prog(0, 0, 0, 32'h200, 32'h200, 1'b1);
        fetch(32'h1FF); fetch(32'h200); fetch(32'h201);
        all_off();

        // R3: operand writes only
        cur_req = "R3";
        prog(1, 1, 0, 32'h2000, 32'h2003, 1'b1);
        operand(32'h2001, 1'b0); operand(32'h2000, 1'b1); operand(32'h2003, 1'b1);
        operand(32'h2004, 1'b1); operand(32'h1FFF, 1'b1);
        all_off();

        // R4: masked instruction value
        cur_req = "R4";
        prog(2, 2, 0, 32'h1234_0000, 32'hFFFF_0000, 1'b1);
        insn(32'h1234_ABCD); insn(32'h1235_0000); insn(32'h1234_0000); insn(32'h0000_1234);
        all_off();

        // R5: taken branch target
        cur_req = "R5";
        prog(3, 3, 0, 32'h4000, 32'h40FF, 1'b1);
        branch(32'h4010, 1'b0); branch(32'h4010, 1'b1); branch(32'h40FF, 1'b1); branch(32'h4100, 1'b1);
        all_off();

        // R6: external trigger and undefined kinds
        cur_req = "R6";
        prog(0, 4, 0, 32'h0, 32'h0, 1'b1);
        prog(1, 6, 0, 32'h0, 32'hFFFF_FFFF, 1'b1);
        idle_in(); step();
        idle_in(); trig_in_n = 1'b0; step();
        idle_in(); trig_in_n = 1'b0; step();
        fetch(32'h10);
        all_off();

        // R7: counted events
        cur_req = "R7";
        prog(1, 0, 2, 32'h500, 32'h50F, 1'b1);
        for (int i = 0; i < 7; i++) fetch(32'h504);
        fetch(32'h600);
        all_off();

        // R9 / R10: process and mode qualifiers
        cur_req = "R9";
        wr(2, 1, 32'h700); wr(2, 2, 32'h7FF);
        ctl(2, 1'b1, 0, 1'b0, 0, 1'b1, 5, 1'b0, 1'b1, 1'b1, 0);
        cur_pid = 8'd4; fetch(32'h710);
        cur_pid = 8'd5; fetch(32'h710);
        cur_req = "R10";
        ctl(2, 1'b1, 0, 1'b0, 0, 1'b1, 0, 1'b1, 1'b1, 1'b0, 0);
        cur_mode = 1'b0; fetch(32'h710);
        cur_mode = 1'b1; fetch(32'h710);
        cur_pid = 8'd0; cur_mode = 1'b0;
        all_off();

        // R8: three-stage ordered sequence 0 -> 1 -> 2
        cur_req = "R8";
        wr(0, 1, 32'hA0); wr(0, 2, 32'hA0);
        wr(1, 1, 32'hB0); wr(1, 2, 32'hB0);
        wr(2, 1, 32'hC0); wr(2, 2, 32'hC0);
        ctl(0, 1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0);
        ctl(1, 1'b1, 0, 1'b1, 0, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0);
        ctl(2, 1'b1, 0, 1'b1, 1, 1'b1, 0, 1'b1, 1'b0, 1'b1, 0);
        fetch(32'hB0); fetch(32'hC0); fetch(32'hA0); fetch(32'hC0);
        fetch(32'hB0); fetch(32'hB0); fetch(32'hC0); fetch(32'hC0);
        fetch(32'hB0);

        // R12: clear strobe disarms a chained stage and zeroes a count
        cur_req = "R12";
        fetch(32'hA0);
        wr(1, 3, 32'h0);
        fetch(32'hB0);
        prog(3, 0, 1, 32'hD0, 32'hD0, 1'b1);
        fetch(32'hD0);
        wr(3, 3, 32'h0);
        fetch(32'hD0); fetch(32'hD0);
        all_off();

        // R11: trigger-out only for enabled channels, one cycle per hit
        cur_req = "R11";
        prog(0, 0, 0, 32'hE0, 32'hE0, 1'b0);
        prog(1, 0, 0, 32'hE0, 32'hE1, 1'b1);
        fetch(32'hE1); fetch(32'hE0); fetch(32'hE1); idle_in(); step(); fetch(32'hE0);
        idle_in(); step();
        all_off();

        // R8: mixed soak with all channels interacting
        cur_req = "R8";
        for (int c = 0; c < 4; c++) begin
            int lo;
            lo = $urandom % 16;
            wr(c, 1, lo);
            wr(c, 2, (c == 2) ? 32'h0000_000C : lo + ($urandom % 8));
            ctl(c, 1'b1, (c == 2) ? 2 : $urandom % 5, c != 0, $urandom % 4, $urandom % 2,
                $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 3);
        end
        for (int i = 0; i < 400; i++) begin
            idle_in();
            fetch_valid = $urandom % 2; fetch_addr = $urandom % 24; insn_word = $urandom;
            op_valid = $urandom % 2; op_write = $urandom % 2; op_addr = $urandom % 24;
            br_taken = $urandom % 2; br_target = $urandom % 24;
            trig_in_n = $urandom % 2; cur_pid = $urandom % 2; cur_mode = $urandom % 2;
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule